// File: doc/BRIEF.md
# Ethernet PHY Serial Management Slave

This block is the management end of an Ethernet PHY's two-wire serial bus. A controller toggles a management clock and drives a shared data line. Inside the chip that line is split into an input, an output and an output enable. The block oversamples the management clock with the system clock and reads the data line on each rising edge of the management clock. It recognises framed read and write commands and compares the frame's 5-bit station address with five static strap inputs. When they match, it reads or writes a small register file.

Register 0 is the control register. Its fields leave the block as plain control pins for the rest of the PHY. The reset and restart-negotiation bits clear themselves. Writing the reset bit puts every register back to its power-on value. Register 1 is a status register. It holds a link bit that latches low and a fault bit that latches high, and each of them is reloaded from its live input when register 1 is read. There is no streaming data path, so every pin is a plain level or pulse.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive 1 bits followed by the start bits 0 then 1. A frame with a shorter run of 1 bits has no effect and causes no drive.
- R2: The 2-bit operation code is sent first-bit-first. 10 means read and 01 means write. A code of 00 or 11 abandons the frame: no register changes, MDIO is never driven, and the block hunts for a new preamble.
- R3: After the operation code come the 5-bit station address and then the 5-bit register number, both most significant bit first. If the station address differs from the strap inputs, the frame is ignored: no write takes place and the output enable stays low.
- R4: On a matched read, MDIO stays released during the first turnaround bit, and the slave drives 0 during the second turnaround bit.
- R5: On a matched read, the slave then drives 16 data bits, most significant bit first, and releases MDIO after the last one. A register number other than 0 or 1 reads as 16'h0000.
- R6: On a matched write to register 0, the slave captures 16 data bits, most significant bit first, after the two turnaround bits. Bit 14 is loopback, bit 13 is speed (1 = 100 Mbps), bit 12 is negotiation enable, bit 11 is power down, bit 10 is isolate, bit 8 is duplex (1 = full) and bit 7 is collision test. Bits 6:0 are ignored and read as 0. Writes to register 1 are ignored.
- R7: After rst_n, register 0 reads 16'h3100: speed, negotiation enable and duplex are 1, and every other bit is 0. Both latch bits of register 1 are 0.
- R8: Writing 1 to bit 15 raises ctl_reset for one clock, restores every register to its reset value and ignores the other written bits. Writing 1 to bit 9 raises ctl_an_restart for one clock. Both bits always read as 0.
- R9: Register 1 bit 2 latches low: it is 0 from any clock where link_in is 0 until register 1 is read. Register 1 bit 4 latches high: it is 1 from any clock where fault_in is 1 until register 1 is read. A read returns the latched value, and both bits are then reloaded from their inputs.
- R10: mdc must be synchronous to clk. A rising edge of mdc is detected on the first clk edge at which mdc is high. MDIO is sampled, and mdio_o, mdio_oe and register updates take effect, at that same clk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples mdc |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the controller |
| mdio_i | input | 1 | Data line as seen by the slave |
| mdio_o | output | 1 | Value the slave drives on the data line |
| mdio_oe | output | 1 | Output enable for the data line |
| phy_addr | input | 5 | Static station address straps |
| link_in | input | 1 | Live link indication for the latch-low bit |
| fault_in | input | 1 | Live fault indication for the latch-high bit |
| ctl_reset | output | 1 | One-clock soft reset pulse |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed100 | output | 1 | 1 selects 100 Mbps |
| ctl_an_en | output | 1 | Negotiation enable |
| ctl_pdown | output | 1 | Power down |
| ctl_isolate | output | 1 | Isolate |
| ctl_an_restart | output | 1 | One-clock negotiation restart pulse |
| ctl_full_duplex | output | 1 | 1 selects full duplex |
| ctl_col_test | output | 1 | Collision test enable |

## Verification
Each result appears on the clk edge that first sees mdc high. A drive value for the next bit, a register write, a latch reload and the start of a reset or restart pulse are all due one clk edge after mdc is raised, with no wait of any further management-clock period. The bench raises mdc at a falling clk edge and updates its behavioural model at that same moment. It compares the data-line pins and all control pins against the model a quarter period after every rising clk edge. This catches any result that comes one cycle early or late, and it catches a pulse that lasts longer than one clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    S_HUNT, S_START, S_OP, S_PHY, S_REG, S_TA, S_DATA
  } mdio_state_e;

  // control register bit positions
  localparam int B_RST     = 15;
  localparam int B_LOOP    = 14;
  localparam int B_SPEED   = 13;
  localparam int B_ANEN    = 12;
  localparam int B_PDOWN   = 11;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_DUPLEX  = 8;
  localparam int B_COLTEST = 7;
  // status register bit positions
  localparam int B_LINK    = 2;
  localparam int B_FAULT   = 4;

  typedef struct packed {
    logic loopback;
    logic speed100;
    logic an_en;
    logic pdown;
    logic isolate;
    logic duplex;
    logic col_test;
  } ctl_t;

  localparam ctl_t CTL_DEFAULT = '{loopback: 1'b0, speed100: 1'b1, an_en: 1'b1,
                                   pdown: 1'b0, isolate: 1'b0, duplex: 1'b1,
                                   col_test: 1'b0};
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc,
  input  logic          mdio_i,
  input  logic [AW-1:0] strap,
  input  logic [DW-1:0] rd_data,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          rd_req,
  output logic          wr_req,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CW   = $clog2(PRE_LEN + 1);
  localparam int NW   = $clog2((DW > AW) ? DW : AW);
  localparam logic [NW-1:0] AW_LAST = NW'(AW - 1);
  localparam logic [NW-1:0] DW_LAST = NW'(DW - 1);

  mdio_state_e   state;
  logic          mdc_q, rise, is_rd;
  logic [CW-1:0] ones;
  logic [NW-1:0] cnt;
  logic [1:0]    op_q;
  logic [1:0]    op_nx;
  logic [AW-1:0] pa_q, ra_q;
  logic [DW-1:0] sh;

  assign rise     = mdc & ~mdc_q;
  assign op_nx    = {op_q[0], mdio_i};
  assign reg_addr = (state == S_REG) ? {ra_q[AW-2:0], mdio_i} : ra_q;
  assign wr_data  = {sh[DW-2:0], mdio_i};
  assign rd_req   = rise && state == S_REG && cnt == AW_LAST && is_rd && pa_q == strap;
  assign wr_req   = rise && state == S_DATA && cnt == DW_LAST && !is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_HUNT;
      mdc_q   <= 1'b0;
      ones    <= '0;
      cnt     <= '0;
      op_q    <= '0;
      is_rd   <= 1'b0;
      pa_q    <= '0;
      ra_q    <= '0;
      sh      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      mdc_q <= mdc;
      if (rise) begin
        case (state)
          S_HUNT: begin
            if (mdio_i) begin
              if (ones != CW'(PRE_LEN)) ones <= ones + CW'(1);
            end else if (ones == CW'(PRE_LEN)) begin
              state <= S_START;
            end else begin
              ones <= '0;
            end
          end
          S_START: begin
            ones <= '0;
            cnt  <= '0;
            state <= mdio_i ? S_OP : S_HUNT;
          end
          S_OP: begin
            op_q <= op_nx;
            if (cnt == NW'(1)) begin
              cnt <= '0;
              if (op_nx == 2'b10 || op_nx == 2'b01) begin
                state <= S_PHY;
                is_rd <= (op_nx == 2'b10);
              end else begin
                state <= S_HUNT;
              end
            end else begin
              cnt <= cnt + NW'(1);
            end
          end
          S_PHY: begin
            pa_q <= {pa_q[AW-2:0], mdio_i};
            if (cnt == AW_LAST) begin
              cnt   <= '0;
              state <= S_REG;
            end else begin
              cnt <= cnt + NW'(1);
            end
          end
          S_REG: begin
            ra_q <= reg_addr;
            if (cnt == AW_LAST) begin
              cnt <= '0;
              if (pa_q == strap) begin
                state <= S_TA;
                if (is_rd) sh <= rd_data;
              end else begin
                state <= S_HUNT;
              end
            end else begin
              cnt <= cnt + NW'(1);
            end
          end
          S_TA: begin
            if (cnt == '0) begin
              cnt <= NW'(1);
              if (is_rd) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              cnt   <= '0;
              state <= S_DATA;
              if (is_rd) begin
                mdio_o <= sh[DW-1];
                sh     <= sh << 1;
              end
            end
          end
          S_DATA: begin
            if (is_rd) begin
              if (cnt == DW_LAST) begin
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b0;
              end else begin
                mdio_o <= sh[DW-1];
                sh     <= sh << 1;
              end
            end else begin
              sh <= wr_data;
            end
            if (cnt == DW_LAST) begin
              cnt   <= '0;
              state <= S_HUNT;
            end else begin
              cnt <= cnt + NW'(1);
            end
          end
          default: state <= S_HUNT;
        endcase
      end
    end
  end

  // R4: the first driven value of a read is the turnaround zero
  a_r4_turnaround_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  // R3: the line is driven only for a frame whose address matched the straps
  a_r3_drive_only_matched: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (pa_q == strap && is_rd));
  // R2: a write strobe only ever follows a write operation code
  a_r2_write_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> op_q == 2'b01);
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          link_in,
  input  logic          fault_in,
  output logic [DW-1:0] rd_data,
  output ctl_t          ctl,
  output logic          rst_pulse,
  output logic          restart_pulse
);
  logic link_l, fault_l;
  logic sel_ctl, sel_stat, soft_rst, snap;
  logic unused_wbits;

  assign sel_ctl      = (reg_addr == AW'(0));
  assign sel_stat     = (reg_addr == AW'(1));
  assign soft_rst     = wr_req && sel_ctl && wr_data[B_RST];
  assign snap         = rd_req && sel_stat;
  assign unused_wbits = ^wr_data[6:0];

  always_comb begin
    rd_data = '0;
    if (sel_ctl) begin
      rd_data[B_LOOP]    = ctl.loopback;
      rd_data[B_SPEED]   = ctl.speed100;
      rd_data[B_ANEN]    = ctl.an_en;
      rd_data[B_PDOWN]   = ctl.pdown;
      rd_data[B_ISO]     = ctl.isolate;
      rd_data[B_DUPLEX]  = ctl.duplex;
      rd_data[B_COLTEST] = ctl.col_test;
    end else if (sel_stat) begin
      rd_data[B_LINK]  = link_l;
      rd_data[B_FAULT] = fault_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl           <= CTL_DEFAULT;
      rst_pulse     <= 1'b0;
      restart_pulse <= 1'b0;
      link_l        <= 1'b0;
      fault_l       <= 1'b0;
    end else begin
      rst_pulse     <= 1'b0;
      restart_pulse <= 1'b0;
      if (soft_rst) begin
        ctl       <= CTL_DEFAULT;
        rst_pulse <= 1'b1;
        link_l    <= 1'b0;
        fault_l   <= 1'b0;
      end else begin
        if (wr_req && sel_ctl) begin
          ctl.loopback  <= wr_data[B_LOOP];
          ctl.speed100  <= wr_data[B_SPEED];
          ctl.an_en     <= wr_data[B_ANEN];
          ctl.pdown     <= wr_data[B_PDOWN];
          ctl.isolate   <= wr_data[B_ISO];
          ctl.duplex    <= wr_data[B_DUPLEX];
          ctl.col_test  <= wr_data[B_COLTEST];
          restart_pulse <= wr_data[B_RESTART];
        end
        if (snap) begin
          link_l  <= link_in;
          fault_l <= fault_in;
        end else begin
          link_l  <= link_l & link_in;
          fault_l <= fault_l | fault_in;
        end
      end
    end
  end

  // R8: self-clearing bits last exactly one clock
  a_r8_reset_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  a_r8_restart_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse);
  // R8: while the reset pulse is high the control fields are at their defaults
  a_r8_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (ctl == CTL_DEFAULT && !link_l && !fault_l));
  // R9: a low link input with no read pending leaves the latch low
  a_r9_latch_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_in && !snap) |=> !link_l);
  // R9: a high fault input with no read or soft reset pending leaves the latch high
  a_r9_latch_high: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && !snap && !soft_rst) |=> fault_l);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic [AW-1:0] phy_addr,
  input  logic          link_in,
  input  logic          fault_in,
  output logic          ctl_reset,
  output logic          ctl_loopback,
  output logic          ctl_speed100,
  output logic          ctl_an_en,
  output logic          ctl_pdown,
  output logic          ctl_isolate,
  output logic          ctl_an_restart,
  output logic          ctl_full_duplex,
  output logic          ctl_col_test
);
  logic          rd_req, wr_req;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] wr_data, rd_data;
  ctl_t          ctl;

  mdio_frame_rx #(.PRE_LEN(PRE_LEN), .AW(AW), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i), .strap(phy_addr),
    .rd_data(rd_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_req(rd_req),
    .wr_req(wr_req), .reg_addr(reg_addr), .wr_data(wr_data)
  );

  mdio_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .reg_addr(reg_addr), .wr_data(wr_data), .link_in(link_in),
    .fault_in(fault_in), .rd_data(rd_data), .ctl(ctl),
    .rst_pulse(ctl_reset), .restart_pulse(ctl_an_restart)
  );

  assign ctl_loopback    = ctl.loopback;
  assign ctl_speed100    = ctl.speed100;
  assign ctl_an_en       = ctl.an_en;
  assign ctl_pdown       = ctl.pdown;
  assign ctl_isolate     = ctl.isolate;
  assign ctl_full_duplex = ctl.duplex;
  assign ctl_col_test    = ctl.col_test;
endmodule

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;
  localparam logic [4:0] STRAP = 5'h0B;

  logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, mdio_i = 1'b1;
  logic link_in = 1'b1, fault_in = 1'b0;
  logic mdio_o, mdio_oe;
  logic ctl_reset, ctl_loopback, ctl_speed100, ctl_an_en, ctl_pdown;
  logic ctl_isolate, ctl_an_restart, ctl_full_duplex, ctl_col_test;

  int checks = 0, errors = 0;
  string tag = "R7";
  bit chk_en = 1'b0;

  // behavioural model state
  logic [15:0] m_reg = 16'h3100;
  logic m_link = 1'b0, m_fault = 1'b0;
  logic exp_rst = 1'b0, exp_rs = 1'b0, exp_oe = 1'b0, exp_o = 1'b0;

  always #10 clk = ~clk;

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .phy_addr(STRAP), .link_in(link_in), .fault_in(fault_in),
    .ctl_reset(ctl_reset), .ctl_loopback(ctl_loopback), .ctl_speed100(ctl_speed100),
    .ctl_an_en(ctl_an_en), .ctl_pdown(ctl_pdown), .ctl_isolate(ctl_isolate),
    .ctl_an_restart(ctl_an_restart), .ctl_full_duplex(ctl_full_duplex),
    .ctl_col_test(ctl_col_test)
  );

  // R10: compare every clock, a quarter period after the active edge
  always @(posedge clk) begin
    #5;
    if (chk_en) begin
      logic [8:0] got, exp;
      got = {ctl_reset, ctl_loopback, ctl_speed100, ctl_an_en, ctl_pdown,
             ctl_isolate, ctl_an_restart, ctl_full_duplex, ctl_col_test};
      exp = {exp_rst, m_reg[14], m_reg[13], m_reg[12], m_reg[11], m_reg[10],
             exp_rs, m_reg[8], m_reg[7]};
      checks += 2;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s: control pins got %b expected %b at %0t", tag, got, exp, $time);
      end
      if ({mdio_oe, mdio_o} !== {exp_oe, exp_o}) begin
        errors++;
        $display("FAIL %s: oe/o got %b%b expected %b%b at %0t", tag, mdio_oe, mdio_o,
                 exp_oe, exp_o, $time);
      end
    end
  end

  function automatic logic [15:0] model_read(input logic [4:0] ra);
    logic [15:0] v = 16'h0000;
    if (ra == 5'd0) v = m_reg;
    else if (ra == 5'd1) begin
      v[2] = m_link;
      v[4] = m_fault;
      m_link  = link_in;
      m_fault = fault_in;
    end
    return v;
  endfunction

  task automatic model_write(input logic [4:0] ra, input logic [15:0] wd);
    if (ra == 5'd0) begin
      if (wd[15]) begin
        m_reg = 16'h3100; exp_rst = 1'b1; m_link = 1'b0; m_fault = 1'b0;
      end else begin
        m_reg = wd & 16'h7D80; exp_rs = wd[9];
      end
    end
  endtask

  task automatic send_frame(input int npre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] wd);
    bit q[$];
    int last;
    bit rd_ok, wr_ok;
    logic [15:0] rdv = 16'h0000;
    for (int k = 0; k < npre; k++) q.push_back(1'b1);
    q.push_back(1'b0); q.push_back(1'b1);
    q.push_back(op[1]); q.push_back(op[0]);
    for (int k = 4; k >= 0; k--) q.push_back(pa[k]);
    for (int k = 4; k >= 0; k--) q.push_back(ra[k]);
    if (op == 2'b10) begin
      for (int k = 0; k < 18; k++) q.push_back(1'b1);
    end else begin
      q.push_back(1'b1); q.push_back(1'b0);
      for (int k = 15; k >= 0; k--) q.push_back(wd[k]);
    end
    last  = npre + 13;
    rd_ok = (npre >= 32) && (op == 2'b10) && (pa == STRAP);
    wr_ok = (npre >= 32) && (op == 2'b01) && (pa == STRAP);
    for (int i = 0; i < q.size(); i++) begin
      mdc = 1'b0; mdio_i = q[i];
      repeat (4) @(negedge clk);
      mdc = 1'b1;
      if (rd_ok) begin
        if (i == last) begin rdv = model_read(ra); exp_oe = 1'b0; exp_o = 1'b0; end
        else if (i == last + 1) begin exp_oe = 1'b1; exp_o = 1'b0; end
        else if (i >= last + 2 && i <= last + 17) begin
          exp_oe = 1'b1; exp_o = rdv[15 - (i - last - 2)];
        end else begin exp_oe = 1'b0; exp_o = 1'b0; end
      end
      if (wr_ok && i == last + 18) model_write(ra, wd);
      @(negedge clk);
      exp_rst = 1'b0; exp_rs = 1'b0;
      repeat (3) @(negedge clk);
    end
    mdc = 1'b0; mdio_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); chk_en = 1'b1;           // R7 reset state compared while in reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R4/R5/R7"; send_frame(32, 2'b10, STRAP, 5'd0, 16'h0);   // reads 3100
    tag = "R6"; send_frame(32, 2'b01, STRAP, 5'd0, 16'h45FF);
    send_frame(32, 2'b10, STRAP, 5'd0, 16'h0);                     // reads 4580
    tag = "R1"; send_frame(31, 2'b01, STRAP, 5'd0, 16'h0000);      // too short
    send_frame(31, 2'b10, STRAP, 5'd0, 16'h0);
    send_frame(40, 2'b10, STRAP, 5'd0, 16'h0);
    tag = "R2"; send_frame(32, 2'b11, STRAP, 5'd0, 16'h0000);
    send_frame(32, 2'b00, STRAP, 5'd0, 16'h0000);
    send_frame(32, 2'b10, STRAP, 5'd0, 16'h0);
    tag = "R3"; send_frame(32, 2'b01, 5'h0A, 5'd0, 16'h0000);
    send_frame(32, 2'b10, 5'h1B, 5'd0, 16'h0);
    send_frame(32, 2'b10, STRAP, 5'd0, 16'h0);
    tag = "R8"; send_frame(32, 2'b01, STRAP, 5'd0, 16'h3300);      // restart pulse
    send_frame(32, 2'b10, STRAP, 5'd0, 16'h0);
    send_frame(32, 2'b01, STRAP, 5'd0, 16'h0880);
    send_frame(32, 2'b01, STRAP, 5'd0, 16'hC480);                  // soft reset
    send_frame(32, 2'b10, STRAP, 5'd0, 16'h0);
    tag = "R5"; send_frame(32, 2'b10, STRAP, 5'd7, 16'h0);
    tag = "R6"; send_frame(32, 2'b01, STRAP, 5'd1, 16'hFFFF);      // read-only reg
    tag = "R9"; send_frame(32, 2'b10, STRAP, 5'd1, 16'h0);         // link 0 since reset
    send_frame(32, 2'b10, STRAP, 5'd1, 16'h0);                     // link 1
    link_in = 1'b0; m_link = 1'b0; repeat (5) @(negedge clk); link_in = 1'b1;
    fault_in = 1'b1; m_fault = 1'b1; repeat (5) @(negedge clk); fault_in = 1'b0;
    repeat (5) @(negedge clk);
    send_frame(32, 2'b10, STRAP, 5'd1, 16'h0);                     // latched 0 / 1
    send_frame(32, 2'b10, STRAP, 5'd1, 16'h0);                     // reloaded
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule